// File: doc/BRIEF.md
# Random allocation tag generator

This block picks a 4-bit allocation tag for a pointer and returns the pointer with that tag in its top-byte tag field. In random mode, a 16-bit Fibonacci LFSR is stepped four times. The four feedback bits form an offset. A forward walk then starts at the stored start tag and skips every tag whose bit is set in an exclusion mask. The chosen tag and the advanced seed are written back to the state register, so the next request continues the sequence.

In the second mode, the walk starts from the tag already held in the pointer and uses an offset given with the request. This mode also adds a signed byte offset to the address and leaves the LFSR state untouched. Software loads a nonzero seed and a start tag through a load strobe. A request is started with a one-cycle strobe and reported complete with a one-cycle done pulse.

Top module: `alloc_tag_gen`

## Requirements
- R1: After reset, busy, done, ptr_out and state_out are all zero.
- R2: In random mode (mode=0), each of four LFSR steps computes b = s[5]^s[3]^s[2]^s[0], shifts the seed right by one and inserts b at bit 15. The b of step i is bit i of the offset.
- R3: In random mode, the exclusion mask is req_mask OR glob_mask, where bit n set excludes tag n. The result is never an excluded tag unless every tag is excluded.
- R4: When all 16 mask bits are set, the result tag is 0.
- R5: With offset 0, the result is the first non-excluded tag counting upward mod 16 from the start tag, and the start tag itself counts.
- R6: With a nonzero offset, each unit of offset advances mod 16 to the next non-excluded tag. The start tag is never counted.
- R7: A random-mode request writes state_out as {seed[15:0] in [23:8], 4'b0 in [7:4], chosen tag in [3:0]}, using the seed advanced by four steps.
- R8: In add mode (mode=1), the start tag is ptr_in[59:56], the offset is tag_off and only glob_mask is used. state_out is not changed.
- R9: ptr_out holds the chosen tag in bits [59:56], and every other bit equals the base pointer. The base is ptr_in in random mode, and ptr_in plus the sign-extended addr_off in add mode.
- R10: start is accepted only while busy is low, and a start seen while busy is ignored. done is a one-cycle pulse, and ptr_out holds its value until the next completion.
- R11: load_state while busy is low writes {load_seed, 4'b0, load_tag} into state_out on the next edge. The strobe is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe |
| mode | input | 1 | 0 = random tag, 1 = add to existing tag |
| ptr_in | input | 64 | Input pointer |
| req_mask | input | 16 | Per-request exclusion mask (random mode) |
| glob_mask | input | 16 | Configured global exclusion mask |
| tag_off | input | 4 | Tag offset for add mode |
| addr_off | input | 16 | Signed address offset for add mode |
| load_state | input | 1 | Load seed and start tag |
| load_seed | input | 16 | Seed to load (must be nonzero) |
| load_tag | input | 4 | Start tag to load |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| ptr_out | output | 64 | Tagged pointer result |
| state_out | output | 24 | State register: seed [23:8], tag [3:0] |

## Verification
On every cycle, the checker confirms four things: a finished walk never lands on an excluded tag, a fully excluded mask yields tag 0, done never lasts two cycles, and the state register changes only on a random-mode completion or an idle load. The LFSR sequence, the inclusive treatment of the start tag at offset 0, the exclusive walk at nonzero offsets and the address arithmetic of add mode can only be shown by the bench's scenarios. The bench compares those results with a reference model built from the requirements. It also checks that a start or a load raised in the middle of a walk is ignored.

// File: rtl/alloc_tag_pkg.sv
package alloc_tag_pkg;
  typedef enum logic {MODE_RAND = 1'b0, MODE_ADD = 1'b1} tag_mode_e;
  typedef enum logic {WK_IDLE = 1'b0, WK_WALK = 1'b1} walk_st_e;
  // feedback taps of the seed register
  localparam int TAP_A = 5;
  localparam int TAP_B = 3;
  localparam int TAP_C = 2;
  localparam int TAP_D = 0;
endpackage

// File: rtl/tag_lfsr_step.sv
module tag_lfsr_step #(
  parameter int SEED_W = 16,
  parameter int STEPS  = 4
) (
  input  logic [SEED_W-1:0] seed_in,
  output logic [SEED_W-1:0] seed_out,
  output logic [STEPS-1:0]  offset
);
  import alloc_tag_pkg::*;
  logic [SEED_W-1:0] chain [STEPS+1];
  logic [STEPS-1:0]  fb;

  assign chain[0] = seed_in;
  for (genvar i = 0; i < STEPS; i++) begin : g_step
    assign fb[i] = chain[i][TAP_A] ^ chain[i][TAP_B] ^ chain[i][TAP_C] ^ chain[i][TAP_D];
    assign chain[i+1] = {fb[i], chain[i][SEED_W-1:1]};
  end
  assign seed_out = chain[STEPS];
  assign offset   = fb;
endmodule

// File: rtl/tag_walker.sv
module tag_walker #(
  parameter int TAG_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  go,
  input  logic [TAG_W-1:0]      start_tag,
  input  logic [TAG_W-1:0]      offset,
  input  logic [(1<<TAG_W)-1:0] mask,
  output logic                  busy,
  output logic                  fin,
  output logic [TAG_W-1:0]      res,
  output logic [(1<<TAG_W)-1:0] mask_o
);
  import alloc_tag_pkg::*;
  localparam int NTAG = 1 << TAG_W;

  walk_st_e        st;
  logic [TAG_W-1:0] cur, rem;
  logic [NTAG-1:0]  mask_q;
  logic [TAG_W-1:0] nxt;
  logic             all_ex;

  assign nxt    = cur + 1'b1;
  assign all_ex = &mask_q;
  assign busy   = (st == WK_WALK);
  assign fin    = busy && (all_ex || (rem == '0 && !mask_q[cur]));
  assign res    = all_ex ? '0 : cur;
  assign mask_o = mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= WK_IDLE;
      cur    <= '0;
      rem    <= '0;
      mask_q <= '0;
    end else begin
      case (st)
        WK_IDLE: if (go) begin
          st     <= WK_WALK;
          cur    <= start_tag;
          rem    <= offset;
          mask_q <= mask;
        end
        WK_WALK: begin
          if (fin) st <= WK_IDLE;
          else begin
            cur <= nxt;
            if (rem != '0 && !mask_q[nxt]) rem <= rem - 1'b1;
          end
        end
        default: st <= WK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/alloc_tag_gen.sv
module alloc_tag_gen #(
  parameter int PTR_W   = 64,
  parameter int TAG_LSB = 56,
  parameter int TAG_W   = 4,
  parameter int SEED_W  = 16,
  parameter int AOFF_W  = 16,
  localparam int NTAG     = 1 << TAG_W,
  localparam int SEED_LSB = 2 * TAG_W,
  localparam int ST_W     = SEED_LSB + SEED_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mode,
  input  logic [PTR_W-1:0]  ptr_in,
  input  logic [NTAG-1:0]   req_mask,
  input  logic [NTAG-1:0]   glob_mask,
  input  logic [TAG_W-1:0]  tag_off,
  input  logic [AOFF_W-1:0] addr_off,
  input  logic              load_state,
  input  logic [SEED_W-1:0] load_seed,
  input  logic [TAG_W-1:0]  load_tag,
  output logic              busy,
  output logic              done,
  output logic [PTR_W-1:0]  ptr_out,
  output logic [ST_W-1:0]   state_out
);
  import alloc_tag_pkg::*;

  logic [ST_W-1:0]   state_q;
  logic [PTR_W-1:0]  base_q, ptr_q, sum, ins;
  logic [SEED_W-1:0] seed_nx_q, lfsr_seed;
  logic [TAG_W-1:0]  lfsr_off, w_start, w_off, w_res;
  logic [NTAG-1:0]   w_mask, w_mask_q;
  logic              w_busy, w_fin, done_q, accept;
  tag_mode_e         mode_q, mode_in;

  assign mode_in = tag_mode_e'(mode);
  assign accept  = start && !w_busy;

  tag_lfsr_step #(.SEED_W(SEED_W), .STEPS(TAG_W)) u_lfsr (
    .seed_in  (state_q[SEED_LSB +: SEED_W]),
    .seed_out (lfsr_seed),
    .offset   (lfsr_off)
  );

  always_comb begin
    if (mode_in == MODE_ADD) begin
      w_start = ptr_in[TAG_LSB +: TAG_W];
      w_off   = tag_off;
      w_mask  = glob_mask;
    end else begin
      w_start = state_q[TAG_W-1:0];
      w_off   = lfsr_off;
      w_mask  = req_mask | glob_mask;
    end
    sum = ptr_in + {{(PTR_W-AOFF_W){addr_off[AOFF_W-1]}}, addr_off};
    ins = base_q;
    ins[TAG_LSB +: TAG_W] = w_res;
  end

  tag_walker #(.TAG_W(TAG_W)) u_walk (
    .clk       (clk),
    .rst       (rst),
    .go        (accept),
    .start_tag (w_start),
    .offset    (w_off),
    .mask      (w_mask),
    .busy      (w_busy),
    .fin       (w_fin),
    .res       (w_res),
    .mask_o    (w_mask_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= '0;
      base_q    <= '0;
      ptr_q     <= '0;
      seed_nx_q <= '0;
      done_q    <= 1'b0;
      mode_q    <= MODE_RAND;
    end else begin
      done_q <= w_fin;
      if (accept) begin
        mode_q    <= mode_in;
        base_q    <= (mode_in == MODE_ADD) ? sum : ptr_in;
        seed_nx_q <= lfsr_seed;
      end
      if (w_fin) begin
        ptr_q <= ins;
        if (mode_q == MODE_RAND)
          state_q <= {seed_nx_q, {(SEED_LSB-TAG_W){1'b0}}, w_res};
      end else if (load_state && !w_busy) begin
        state_q <= {load_seed, {(SEED_LSB-TAG_W){1'b0}}, load_tag};
      end
    end
  end

  assign busy      = w_busy;
  assign done      = done_q;
  assign ptr_out   = ptr_q;
  assign state_out = state_q;
endmodule

// File: rtl/alloc_tag_gen_chk.sv
module alloc_tag_gen_chk #(
  parameter int TAG_W = 4,
  parameter int ST_W  = 24
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  start,
  input logic                  busy,
  input logic                  done,
  input logic                  fin,
  input logic [TAG_W-1:0]      res,
  input logic [(1<<TAG_W)-1:0] mask_q,
  input logic                  mode_q,
  input logic                  load_state,
  input logic [ST_W-1:0]       state_out
);
  AST_RES_NOT_EXCLUDED: assert property (@(posedge clk) disable iff (rst)
    (fin && !(&mask_q)) |-> !mask_q[res]); // R3
  AST_ALL_EXCLUDED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (fin && (&mask_q)) |-> (res == '0)); // R4
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_START_TAKES: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R10
  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!(fin && !mode_q) && !(load_state && !busy)) |=> $stable(state_out)); // R11
endmodule

bind alloc_tag_gen alloc_tag_gen_chk #(.TAG_W(TAG_W), .ST_W(ST_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .busy       (w_busy),
  .done       (done_q),
  .fin        (w_fin),
  .res        (w_res),
  .mask_q     (w_mask_q),
  .mode_q     (mode_q),
  .load_state (load_state),
  .state_out  (state_q)
);

// File: tb/alloc_tag_gen_test.sv
module alloc_tag_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, mode = 1'b0, load_state = 1'b0;
  logic [63:0] ptr_in = '0;
  logic [15:0] req_mask = '0, glob_mask = '0, addr_off = '0, load_seed = '0;
  logic [3:0]  tag_off = '0, load_tag = '0;
  logic        busy, done;
  logic [63:0] ptr_out;
  logic [23:0] state_out;

  int n_chk = 0, n_fail = 0;
  logic [15:0] m_seed;
  logic [3:0]  m_tag;

  always #2 clk = ~clk;

  alloc_tag_gen uut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .ptr_in(ptr_in),
    .req_mask(req_mask), .glob_mask(glob_mask), .tag_off(tag_off),
    .addr_off(addr_off), .load_state(load_state), .load_seed(load_seed),
    .load_tag(load_tag), .busy(busy), .done(done), .ptr_out(ptr_out),
    .state_out(state_out)
  );

  typedef struct packed {
    logic        md;
    logic [63:0] p;
    logic [15:0] rm;
    logic [3:0]  to;
    logic [15:0] ao;
    logic [15:0] gm;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 64'h0123_4567_89ab_cdef, 16'h0000, 4'h0, 16'h0000, 16'h0000},
    '{1'b0, 64'h0f00_0000_0000_1000, 16'h00f0, 4'h0, 16'h0000, 16'h0001},
    '{1'b0, 64'hffff_ffff_ffff_fff0, 16'h5555, 4'h0, 16'h0000, 16'h0000},
    '{1'b1, 64'h0300_0000_0000_0100, 16'hffff, 4'h2, 16'h0010, 16'h0010},
    '{1'b1, 64'h0e00_0000_0000_0008, 16'h0000, 4'hf, 16'hfff0, 16'h4000},
    '{1'b0, 64'h5a00_0000_dead_beef, 16'h8001, 4'h0, 16'h0000, 16'h0660},
    '{1'b1, 64'h0700_1234_0000_0000, 16'h0000, 4'h1, 16'h7fff, 16'h0100},
    '{1'b0, 64'h0000_0000_0000_0040, 16'h3c3c, 4'h0, 16'h0000, 16'h0000}
  };

  function automatic logic [19:0] m_lfsr(input logic [15:0] s);
    logic [3:0] o;
    for (int i = 0; i < 4; i++) begin
      logic b;
      b = s[5] ^ s[3] ^ s[2] ^ s[0];
      s = {b, s[15:1]};
      o[i] = b;
    end
    return {s, o};
  endfunction

  function automatic logic [3:0] m_pick(input logic [3:0] s, input logic [3:0] off,
                                        input logic [15:0] m);
    logic [3:0] t;
    t = s;
    if (&m) return 4'h0;
    if (off == 4'h0) begin
      for (int i = 0; i < 16; i++) if (m[t]) t = t + 1'b1;
    end else begin
      for (int k = 0; k < 16; k++) begin
        if (k < int'(off)) begin
          t = t + 1'b1;
          for (int i = 0; i < 16; i++) if (m[t]) t = t + 1'b1;
        end
      end
    end
    return t;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [15:0] s, input logic [3:0] t);
    @(negedge clk);
    load_state = 1'b1; load_seed = s; load_tag = t;
    @(negedge clk);
    load_state = 1'b0;
    m_seed = s; m_tag = t;
  endtask

  // disturb: raise a start and a load while busy; both must be ignored
  task automatic run(input vec_t v, input string req, input bit disturb);
    logic [63:0] ep;
    logic [19:0] lf;
    logic [3:0]  t;
    int          wd;
    if (v.md == 1'b0) begin
      lf = m_lfsr(m_seed);
      t  = m_pick(m_tag, lf[3:0], v.rm | v.gm);
      ep = v.p;
      m_seed = lf[19:4]; m_tag = t;
    end else begin
      t  = m_pick(v.p[59:56], v.to, v.gm);
      ep = v.p + {{48{v.ao[15]}}, v.ao};
    end
    ep[59:56] = t;
    @(negedge clk);
    mode = v.md; ptr_in = v.p; req_mask = v.rm; tag_off = v.to;
    addr_off = v.ao; glob_mask = v.gm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      start = 1'b1; ptr_in = ~v.p; mode = ~v.md;
      load_state = 1'b1; load_seed = 16'hbeef; load_tag = 4'h9;
      @(negedge clk);
      start = 1'b0; load_state = 1'b0;
    end
    wd = 0;
    while (!done && wd < 1000) begin
      @(negedge clk);
      wd++;
    end
    if (wd >= 1000) begin
      n_chk++; n_fail++;
      $display("FAIL %s watchdog actual=timeout expected=done", req);
    end
    chk(req, ptr_out, ep);
    chk(req, {40'h0, state_out}, {40'h0, m_seed, 4'h0, m_tag});
    @(negedge clk);
    chk("R10 done pulse", {63'h0, done}, 64'h0);
    chk("R10 ptr_out hold", ptr_out, ep);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", {63'h0, busy}, 64'h0);
    chk("R1 done", {63'h0, done}, 64'h0);
    chk("R1 ptr_out", ptr_out, 64'h0);
    chk("R1 state_out", {40'h0, state_out}, 64'h0);
    rst = 1'b0;

    load(16'h0001, 4'h3);
    chk("R11 load", {40'h0, state_out}, 64'h00_0001_03);

    // seed 1: steps give offset 1, seed 0x1000; start 3 -> tag 4 (R2 R6)
    run('{1'b0, 64'h0, 16'h0, 4'h0, 16'h0, 16'h0}, "R2 R6 R7", 1'b0);
    chk("R2 seed value", {40'h0, state_out}, 64'h10_0004);

    load(16'hace1, 4'h6);
    for (int i = 0; i < NV; i++)
      run(VECS[i], VECS[i].md ? "R8 R9 vector" : "R3 R7 R9 vector", 1'b0);

    // R4: every tag excluded
    run('{1'b0, 64'h0a00_0000_0000_0000, 16'hff00, 4'h0, 16'h0, 16'h00ff}, "R4 all excluded", 1'b0);
    chk("R4 tag zero", {60'h0, ptr_out[59:56]}, 64'h0);
    run('{1'b1, 64'h0b00_0000_0000_0000, 16'h0, 4'h5, 16'h0, 16'hffff}, "R4 add all excluded", 1'b0);

    // R5: offset 0, start tag usable -> unchanged; start excluded -> next free
    run('{1'b1, 64'h0500_0000_0000_0000, 16'h0, 4'h0, 16'h0, 16'h0000}, "R5 inclusive", 1'b0);
    chk("R5 same tag", {60'h0, ptr_out[59:56]}, 64'h5);
    run('{1'b1, 64'h0e00_0000_0000_0000, 16'h0, 4'h0, 16'h0, 16'hc000}, "R5 wrap", 1'b0);
    chk("R5 wrap to 0", {60'h0, ptr_out[59:56]}, 64'h0);

    // R6: offset 1 from a free start skips the start itself
    run('{1'b1, 64'h0200_0000_0000_0000, 16'h0, 4'h1, 16'h0, 16'h0018}, "R6 skip", 1'b0);
    chk("R6 tag 5", {60'h0, ptr_out[59:56]}, 64'h5);

    // R10 R11: start and load while busy are ignored
    run('{1'b0, 64'h0123_0000_0000_0000, 16'h0f0f, 4'h0, 16'h0, 16'h0}, "R10 R11 busy ignore", 1'b1);
    run('{1'b1, 64'h0900_0000_0000_0010, 16'h0, 4'h7, 16'h8000, 16'h0202}, "R10 R11 busy ignore add", 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule